// File: doc/BRIEF.md
# CAN Bit Synchronization Unit

This unit keeps a node's bit clock locked to a non-return-to-zero serial bus that carries no clock of its own. It counts time quanta, delivered as single-cycle `tq_tick` enables, through four segments of each bit: a one-quantum sync segment, a propagation segment, a first phase segment and a second phase segment. The received level is captured at the sample point, which is the end of the first phase segment. A strobe marks the start of every bit so that a transmitter can launch its next bit there.

Alignment uses falling edges, from recessive (1) to dominant (0), seen between two consecutive quanta. While the bus is idle, a usable edge restarts the bit outright (hard synchronization). While a frame is running, a usable edge moves the bit boundary by no more than the jump width (re-synchronization). An edge before the sample point stretches the first phase segment. An edge after it trims the second. An edge is usable only when the last sampled value was recessive, and only one is taken between two sample points.

Segment lengths and the jump width are static configuration inputs that every node on a bus shares. All lengths count quanta and must be at least 1.

Top module: `bit_timing_sync`

## Requirements
- R1: After reset, `smp_bit` is 1 (recessive) and both `smp_stb` and `bit_stb` are 0.
- R2: With no usable edge, a bit lasts N = 1 + `prop_len` + `ph1_len` + `ph2_len` quanta. `bit_stb` pulses for one cycle after the tick that ends the last quantum of a bit, and time advances only on `tq_tick`.
- R3: `smp_stb` pulses for one cycle after the tick that ends the last quantum of the first phase segment. `smp_bit` then holds the `rx_bit` value present on that tick.
- R4: A rising edge (rx 0 on one tick, 1 on the next) never moves the bit timing.
- R5: A falling edge is ignored when the last sampled value (`smp_bit`) is 0.
- R6: After one synchronization has been applied, later falling edges are ignored until the next sample point.
- R7: With `bus_idle` high, a usable falling edge seen on a tick produces `bit_stb` after that tick, and the following quantum is a sync segment.
- R8: With `bus_idle` low, a falling edge seen on the tick ending the sync segment (quantum index 0 of the bit) changes nothing.
- R9: With `bus_idle` low, a usable edge on the tick ending quantum q of the propagation or first phase segment (1 ≤ q ≤ `prop_len`+`ph1_len`) lengthens the first phase segment by min(q, `sjw_len`) quanta. This delays both the sample point and the bit end by that amount.
- R10: With `bus_idle` low, a usable edge on the tick ending quantum k of the second phase segment (k from 0) removes min(R, `sjw_len`) of the R = `ph2_len`−1−k quanta that would have followed.
- R11: `smp_stb` and `bit_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tq_tick | input | 1 | One-cycle enable marking the end of a time quantum |
| rx_bit | input | 1 | Synchronised receive level, 1 recessive, 0 dominant |
| bus_idle | input | 1 | High while no frame is in progress; enables hard synchronization |
| prop_len | input | LEN_W | Propagation segment length in quanta |
| ph1_len | input | LEN_W | First phase segment length in quanta |
| ph2_len | input | LEN_W | Second phase segment length in quanta |
| sjw_len | input | LEN_W | Synchronization jump width in quanta |
| smp_bit | output | 1 | Last sampled bus value |
| smp_stb | output | 1 | One-cycle pulse at each sample point |
| bit_stb | output | 1 | One-cycle pulse at each bit start |

## Verification
A wrong segment counter or a wrong stretch amount shows up as a `smp_stb` or `bit_stb` that arrives one or more quanta early or late, inside the same bit that received the edge. A stuck edge-usage flag or a stale last-sample value lets a forbidden second edge or a dominant-to-dominant edge move the boundary. That appears as a shifted sample strobe within a few quanta, or as a different `smp_bit`. Each case is measured in quanta from a bit start that is known through a hard synchronization, so every slip is visible on the ports within one bit.

// File: rtl/bts_pkg.sv
package bts_pkg;
  // Segment within the nominal bit time; order follows the bit.
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/bts_edge_qual.sv
module bts_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_tick,
  input  logic rx_bit,
  input  logic last_smp,
  input  logic smp_evt,
  input  logic sync_evt,
  output logic edge_ok
);
  logic prev_q, prev_d;
  logic used_q, used_d;

  always_comb begin
    prev_d = prev_q;
    used_d = used_q;
    if (tq_tick) begin
      prev_d = rx_bit;
      if (sync_evt)     used_d = 1'b1;
      else if (smp_evt) used_d = 1'b0;
    end
  end

  // Falling edge between two quanta, previous sample recessive, no sync yet
  assign edge_ok = tq_tick & prev_q & ~rx_bit & last_smp & ~used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      used_q <= 1'b0;
    end else if (tq_tick) begin
      prev_q <= prev_d;
      used_q <= used_d;
    end
  end

  // R6
  sync_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && sync_evt) |=> !edge_ok);

  // R5
  dominant_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ok) |-> last_smp);
endmodule

// File: rtl/bts_phase_calc.sv
module bts_phase_calc
  import bts_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  seg_e               seg,
  input  logic [LEN_W:0]     cnt,
  input  logic [LEN_W-1:0]   prop_len,
  input  logic [LEN_W-1:0]   ph2_len,
  input  logic [LEN_W-1:0]   sjw_len,
  output logic [LEN_W-1:0]   lead_ext,
  output logic               cut_all,
  output logic [LEN_W:0]     skip_cnt
);
  localparam int CW = LEN_W + 1;
  localparam int QW = LEN_W + 2;

  logic [QW-1:0] q_pos;
  logic [CW-1:0] rem;

  // Quantum index of the edge inside the bit (sync segment is 0)
  always_comb begin
    if (seg == SEG_PH1) q_pos = QW'(prop_len) + QW'(cnt) + QW'(1);
    else                q_pos = QW'(cnt) + QW'(1);
  end

  always_comb begin
    lead_ext = (q_pos >= QW'(sjw_len)) ? sjw_len : q_pos[LEN_W-1:0];
  end

  always_comb begin
    rem      = {1'b0, ph2_len} - CW'(1) - cnt;
    cut_all  = (rem <= {1'b0, sjw_len});
    skip_cnt = cnt + CW'(1) + {1'b0, sjw_len};
  end
endmodule

// File: rtl/bts_seg_ctrl.sv
module bts_seg_ctrl
  import bts_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tq_tick,
  input  logic               rx_bit,
  input  logic               bus_idle,
  input  logic               edge_ok,
  input  logic [LEN_W-1:0]   prop_len,
  input  logic [LEN_W-1:0]   ph1_len,
  input  logic [LEN_W-1:0]   ph2_len,
  input  logic [LEN_W-1:0]   sjw_len,
  input  logic [LEN_W-1:0]   lead_ext,
  input  logic               cut_all,
  input  logic [LEN_W:0]     skip_cnt,
  output seg_e               seg,
  output logic [LEN_W:0]     cnt,
  output logic               smp_evt,
  output logic               sync_evt,
  output logic               smp_bit,
  output logic               smp_stb,
  output logic               bit_stb
);
  localparam int CW = LEN_W + 1;

  seg_e             seg_q, seg_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LEN_W-1:0] ext_q, ext_d, ext_n;
  logic             smp_q, smp_d;
  logic             sstb_q, sstb_d;
  logic             bstb_q, bstb_d;
  logic             hard, resync;
  logic [CW-1:0]    prop_last, ph1_last, ph2_last;

  always_comb begin
    hard      = edge_ok & bus_idle;
    resync    = edge_ok & ~bus_idle & (seg_q != SEG_SYNC);
    ext_n     = resync ? lead_ext : ext_q;
    prop_last = {1'b0, prop_len} - CW'(1);
    ph1_last  = {1'b0, ph1_len} + {1'b0, ext_n} - CW'(1);
    ph2_last  = {1'b0, ph2_len} - CW'(1);
  end

  always_comb begin
    seg_d    = seg_q;
    cnt_d    = cnt_q;
    ext_d    = ext_q;
    smp_d    = smp_q;
    sstb_d   = 1'b0;
    bstb_d   = 1'b0;
    smp_evt  = 1'b0;
    sync_evt = 1'b0;
    if (tq_tick) begin
      if (hard) begin
        seg_d    = SEG_SYNC;
        cnt_d    = '0;
        ext_d    = '0;
        bstb_d   = 1'b1;
        sync_evt = 1'b1;
      end else begin
        case (seg_q)
          SEG_SYNC: begin
            seg_d = SEG_PROP;
            cnt_d = '0;
          end
          SEG_PROP: begin
            ext_d    = ext_n;
            sync_evt = resync;
            if (cnt_q == prop_last) begin
              seg_d = SEG_PH1;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
          SEG_PH1: begin
            ext_d    = ext_n;
            sync_evt = resync;
            if (cnt_q == ph1_last) begin
              seg_d   = SEG_PH2;
              cnt_d   = '0;
              smp_d   = rx_bit;
              sstb_d  = 1'b1;
              smp_evt = 1'b1;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
          default: begin
            if (resync) begin
              sync_evt = 1'b1;
              if (cut_all) begin
                seg_d  = SEG_SYNC;
                cnt_d  = '0;
                ext_d  = '0;
                bstb_d = 1'b1;
              end else begin
                cnt_d = skip_cnt;
              end
            end else if (cnt_q == ph2_last) begin
              seg_d  = SEG_SYNC;
              cnt_d  = '0;
              ext_d  = '0;
              bstb_d = 1'b1;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
      ext_q <= '0;
      smp_q <= 1'b1;
    end else if (tq_tick) begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
      ext_q <= ext_d;
      smp_q <= smp_d;
    end
  end

  // Strobes are one-cycle pulses, so they load every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sstb_q <= 1'b0;
      bstb_q <= 1'b0;
    end else begin
      sstb_q <= sstb_d;
      bstb_q <= bstb_d;
    end
  end

  assign seg     = seg_q;
  assign cnt     = cnt_q;
  assign smp_bit = smp_q;
  assign smp_stb = sstb_q;
  assign bit_stb = bstb_q;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sstb_q && bstb_q));

  // R2
  ph2_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_PH2) |-> (cnt_q < {1'b0, ph2_len}));

  // R9
  ext_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q <= sjw_len);

  // R3
  smp_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sstb_q |-> $past(tq_tick));

  // R8
  sync_noadj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && seg_q == SEG_SYNC && !bus_idle) |=> (seg_q == SEG_PROP && ext_q == '0));
endmodule

// File: rtl/bit_timing_sync.sv
module bit_timing_sync
  import bts_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             rx_bit,
  input  logic             bus_idle,
  input  logic [LEN_W-1:0] prop_len,
  input  logic [LEN_W-1:0] ph1_len,
  input  logic [LEN_W-1:0] ph2_len,
  input  logic [LEN_W-1:0] sjw_len,
  output logic             smp_bit,
  output logic             smp_stb,
  output logic             bit_stb
);
  seg_e             seg;
  logic [LEN_W:0]   cnt;
  logic [LEN_W:0]   skip_cnt;
  logic [LEN_W-1:0] lead_ext;
  logic             cut_all;
  logic             edge_ok;
  logic             smp_evt;
  logic             sync_evt;

  bts_edge_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .tq_tick  (tq_tick),
    .rx_bit   (rx_bit),
    .last_smp (smp_bit),
    .smp_evt  (smp_evt),
    .sync_evt (sync_evt),
    .edge_ok  (edge_ok)
  );

  bts_phase_calc #(.LEN_W(LEN_W)) u_calc (
    .seg      (seg),
    .cnt      (cnt),
    .prop_len (prop_len),
    .ph2_len  (ph2_len),
    .sjw_len  (sjw_len),
    .lead_ext (lead_ext),
    .cut_all  (cut_all),
    .skip_cnt (skip_cnt)
  );

  bts_seg_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tq_tick  (tq_tick),
    .rx_bit   (rx_bit),
    .bus_idle (bus_idle),
    .edge_ok  (edge_ok),
    .prop_len (prop_len),
    .ph1_len  (ph1_len),
    .ph2_len  (ph2_len),
    .sjw_len  (sjw_len),
    .lead_ext (lead_ext),
    .cut_all  (cut_all),
    .skip_cnt (skip_cnt),
    .seg      (seg),
    .cnt      (cnt),
    .smp_evt  (smp_evt),
    .sync_evt (sync_evt),
    .smp_bit  (smp_bit),
    .smp_stb  (smp_stb),
    .bit_stb  (bit_stb)
  );

  // R7
  hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && bus_idle && edge_ok) |=> bit_stb);

  // R4
  rise_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && rx_bit) |-> !edge_ok);
endmodule

// File: tb/bit_timing_sync_tb.sv
module bit_timing_sync_tb;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tq_tick;
  logic             rx_bit;
  logic             bus_idle;
  logic [LEN_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;
  logic             smp_bit, smp_stb, bit_stb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bit_timing_sync #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_bit(rx_bit),
    .bus_idle(bus_idle), .prop_len(prop_len), .ph1_len(ph1_len),
    .ph2_len(ph2_len), .sjw_len(sjw_len), .smp_bit(smp_bit),
    .smp_stb(smp_stb), .bit_stb(bit_stb)
  );

  // prop, ph1, ph2, sjw, edge quantum q, sample offset, bit-end offset, sampled value
  localparam int NV = 12;
  localparam int VEC [NV][8] = '{
    '{2, 3, 3, 2, 0,  6,  9, 0},
    '{2, 3, 3, 2, 1,  7, 10, 0},
    '{2, 3, 3, 2, 4,  8, 11, 0},
    '{2, 3, 3, 2, 5,  8, 11, 0},
    '{2, 3, 3, 2, 6,  6,  7, 1},
    '{2, 3, 3, 2, 8,  6,  9, 1},
    '{1, 4, 4, 1, 3,  7, 11, 0},
    '{1, 4, 4, 1, 6,  6,  9, 1},
    '{1, 4, 4, 1, 9,  6, 10, 1},
    '{3, 2, 5, 4, 2,  8, 13, 0},
    '{3, 2, 5, 4, 6,  6,  7, 1},
    '{3, 2, 5, 4, 5, 10, 15, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int p, input int a, input int b, input int s);
    rst_n = 1'b0; tq_tick = 1'b0; rx_bit = 1'b1; bus_idle = 1'b1;
    prop_len = LEN_W'(p); ph1_len = LEN_W'(a); ph2_len = LEN_W'(b); sjw_len = LEN_W'(s);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tq(input logic rx, output logic s, output logic b, output logic v);
    @(negedge clk);
    rx_bit = rx; tq_tick = 1'b1;
    @(negedge clk);
    tq_tick = 1'b0;
    s = smp_stb; b = bit_stb; v = smp_bit;
  endtask

  function automatic logic rx_at(input int mode, input int rel, input int n,
                                 input int pa, input int q);
    if (mode == 0) return (rel <= 1 + pa) ? 1'b0 : ((rel < 2 * n + 1 + q) ? 1'b1 : 1'b0);
    if (mode == 1) return (rel <= 6) ? 1'b0 : ((rel <= 10) ? 1'b1 : 1'b0);
    if (rel <= 6)  return 1'b0;
    if (rel <= 19) return 1'b1;
    if (rel == 20) return 1'b0;
    if (rel == 21) return 1'b1;
    return 1'b0;
  endfunction

  // Hard-syncs, then plays a pattern; offsets measured from tick `win` after the sync
  task automatic run(input int p, input int a, input int b, input int s, input int q,
                     input int mode, input int win,
                     output int fb0, output int fs, output int sv, output int fb);
    logic so, bo, vo;
    int n;
    n = 1 + p + a + b;
    do_reset(p, a, b, s);
    // R1
    check(!smp_stb && !bit_stb && smp_bit, "R1 reset state",
          {29'd0, smp_stb, bit_stb, smp_bit}, 1);
    repeat (3) tq(1'b1, so, bo, vo);
    tq(1'b0, so, bo, vo);
    // R7
    check(bo == 1'b1, "R7 hard sync bit start", int'(bo), 1);
    bus_idle = 1'b0;
    fb0 = -1; fs = -1; fb = -1; sv = -1;
    for (int rel = 1; rel <= win + 40 && (fs < 0 || fb < 0); rel++) begin
      tq(rx_at(mode, rel, n, p + a, q), so, bo, vo);
      if (bo && fb0 < 0) fb0 = rel;
      if (rel > win) begin
        if (so && fs < 0) begin fs = rel - win; sv = int'(vo); end
        if (bo && fb < 0) fb = rel - win;
      end
    end
  endtask

  initial begin
    int fb0, fs, sv, fb, n;
    string tag;
    for (int i = 0; i < NV; i++) begin
      n = 1 + VEC[i][0] + VEC[i][1] + VEC[i][2];
      run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 0, 2 * n, fb0, fs, sv, fb);
      if (VEC[i][4] == 0)                          tag = "R8 sync-segment edge";
      else if (VEC[i][4] <= VEC[i][0] + VEC[i][1]) tag = "R9 lengthen phase 1";
      else                                         tag = "R10 shorten phase 2";
      // R2 nominal first bit after hard sync
      check(fb0 == n, "R2 nominal bit length", fb0, n);
      // R3 sample point position and value
      check(fs == VEC[i][5], {tag, " / R3 sample offset"}, fs, VEC[i][5]);
      check(sv == VEC[i][7], "R3 sampled value", sv, VEC[i][7]);
      check(fb == VEC[i][6], {tag, " bit end"}, fb, VEC[i][6]);
    end

    // R4 rising edge in phase 2 leaves bit end alone; R5 edge after dominant sample ignored
    run(2, 3, 3, 2, 0, 1, 9, fb0, fs, sv, fb);
    check(fb0 == 9, "R4 rising edge ignored", fb0, 9);
    check(fs == 6, "R5 edge after dominant sample, sample offset", fs, 6);
    check(sv == 0, "R5 sampled value", sv, 0);
    check(fb == 9, "R5 edge after dominant sample, bit end", fb, 9);

    // R6 second falling edge in the same bit ignored
    run(2, 3, 3, 2, 0, 2, 18, fb0, fs, sv, fb);
    check(fs == 7, "R6 one sync per bit, sample offset", fs, 7);
    check(sv == 0, "R6 sampled value", sv, 0);
    check(fb == 10, "R6 one sync per bit, bit end", fb, 10);

    // R11 strobes never coincide, watched over a free-running stretch
    begin
      logic so, bo, vo;
      int both = 0;
      do_reset(1, 1, 1, 1);
      for (int k = 0; k < 40; k++) begin
        tq(k[2], so, bo, vo);
        if (so && bo) both++;
      end
      check(both == 0, "R11 strobes exclusive", both, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule